// File: doc/BRIEF.md
# Binary Matrix Systematic-Form Reducer

The block takes a small binary matrix of `ROWS` rows by `COLS` columns and reduces it over GF(2) to the systematic form [I | K]. The leftmost `ROWS` columns become an identity matrix, and the remaining columns hold the key part K. Rows arrive one per handshake on a valid/ready stream after a start pulse. One processing element per row holds that row. For each column, all elements act together in one step: a priority search picks a pivot, the pivot row is swapped into place if needed, and every affected row is XORed with the pivot row.

Reduction runs in two passes. A forward pass walks the pivot columns left to right, choosing a pivot and clearing the entries below it. A backward pass walks right to left and clears the entries above each pivot. If the left square part has no pivot in some column, the block raises a one-cycle fail pulse, produces no output, and goes back to idle. Otherwise it raises a one-cycle done pulse and streams the reduced rows out in row order, with back-pressure.

Top module: `gf2_sysform`

## Requirements
- R1: Every output row i carries a single 1 within the left `ROWS` columns, and that 1 sits in column i. Column j of a row is bit `COLS-1-j` of the row word, so column 0 is the MSB.
- R2: Each input row equals the XOR of the output rows i for which that input row has a 1 in column i. The output therefore spans the same row space as the input.
- R3: The output rows equal the unique reduced form, including the K columns. When the current row has a 0 in the pivot column, the first lower row with a 1 there is swapped in as the pivot.
- R4: A start pulse in idle opens loading. `in_ready` stays high until `ROWS` rows have been taken. Rows are taken in order from row 0, only on cycles where both `in_valid` and `in_ready` are high, and idle gaps in `in_valid` are allowed.
- R5: When the left part is non-singular, `done` is high for exactly one cycle. It rises 2*`ROWS`-1 clock edges after the edge that accepts the last input row, in the same cycle as the first output row.
- R6: When the left part is singular, `fail` is high for one cycle. In that cycle `done`, `out_valid` and `busy` are low, and the block then waits in idle for a new start.
- R7: Output rows appear in row order. Each row holds stable while `out_ready` is low. After the last row is taken, the block returns to idle.
- R8: A start pulse while `busy` is high has no effect on loading, on the result, on its timing, or on the return to idle.
- R9: `busy` goes high at the edge that takes a start in idle and stays high until the block returns to idle.
- R10: After reset, `busy`, `in_ready`, `out_valid`, `done` and `fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new matrix; honoured only in idle |
| in_valid | input | 1 | Input row present |
| in_ready | output | 1 | Block accepts an input row |
| in_row | input | COLS | Input row, column 0 in the MSB |
| busy | output | 1 | Block is loading, reducing or emitting |
| done | output | 1 | One-cycle pulse: reduction succeeded |
| fail | output | 1 | One-cycle pulse: left part singular |
| out_valid | output | 1 | Output row present |
| out_ready | input | 1 | Consumer takes the output row |
| out_row | output | COLS | Reduced output row, column 0 in the MSB |

## Verification
The bench builds matrices that force a pivot swap in the first column, matrices whose left part is already an identity or a reversed identity, and matrices made singular either by a dependent row or by an all-zero left column. A design that skipped the swap would report a false failure or leave a 0 on the diagonal. A design that skipped the backward pass would leave stray 1s above the diagonal and break the identity check. A design that missed the singular cases would emit a bogus result instead of a fail pulse. The bench also stalls the output, inserts gaps into the input, and pulses start during loading, reduction and output. A design that restarted on those pulses would lose rows or shift the done cycle.

// File: rtl/gf2sys_pkg.sv
package gf2sys_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_FWD  = 3'd2,
        ST_BWD  = 3'd3,
        ST_OUT  = 3'd4
    } sys_state_e;

endpackage

// File: rtl/gf2sys_pivot.sv
module gf2sys_pivot #(
    parameter int ROWS = 8,
    parameter int IDXW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic [ROWS-1:0] colbits,
    input  logic [IDXW-1:0] from_idx,
    output logic            found,
    output logic [IDXW-1:0] pvt_idx
);

    // lowest row index at or after from_idx with a 1 in the pivot column
    always_comb begin
        found   = 1'b0;
        pvt_idx = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (colbits[i] && (IDXW'(i) >= from_idx)) begin
                found   = 1'b1;
                pvt_idx = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/gf2sys_pe.sv
module gf2sys_pe #(
    parameter int COLS   = 16,
    parameter int IDXW   = 3,
    parameter int COLW   = 4,
    parameter int MY_IDX = 0
) (
    input  logic            mode_fwd,
    input  logic            mode_bwd,
    input  logic [IDXW-1:0] cur_idx,
    input  logic [IDXW-1:0] pvt_idx,
    input  logic [COLW-1:0] col_pos,
    input  logic [COLS-1:0] own_row,
    input  logic [COLS-1:0] cur_row,
    input  logic [COLS-1:0] pvt_row,
    output logic [COLS-1:0] nxt_row
);

    logic [COLS-1:0] base_row;
    logic            is_cur;
    logic            is_pvt;
    logic            below;
    logic            above;

    assign is_cur = (int'(cur_idx) == MY_IDX);
    assign is_pvt = (int'(pvt_idx) == MY_IDX);
    assign below  = (MY_IDX > int'(cur_idx));
    assign above  = (MY_IDX < int'(cur_idx));

    always_comb begin
        base_row = is_pvt ? cur_row : own_row;
        nxt_row  = own_row;
        if (mode_fwd) begin
            if (is_cur) begin
                nxt_row = pvt_row;
            end else if (below && base_row[col_pos]) begin
                nxt_row = base_row ^ pvt_row;
            end else begin
                nxt_row = base_row;
            end
        end else if (mode_bwd) begin
            if (above && own_row[col_pos]) begin
                nxt_row = own_row ^ pvt_row;
            end
        end
    end

endmodule

// File: rtl/gf2_sysform.sv
module gf2_sysform
    import gf2sys_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [COLS-1:0] in_row,
    output logic            busy,
    output logic            done,
    output logic            fail,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [COLS-1:0] out_row
);

    localparam int IDXW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int COLW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(ROWS - 1);

    typedef struct packed {
        sys_state_e                  st;
        logic [IDXW-1:0]             cnt;
        logic [ROWS-1:0][COLS-1:0]   rows;
        logic                        done;
        logic                        fail;
    } regs_t;

    regs_t d, q;

    logic [COLW-1:0]           col_pos;
    logic [ROWS-1:0]           colbits;
    logic                      pvt_found;
    logic [IDXW-1:0]           pvt_idx;
    logic [COLS-1:0]           pvt_row;
    logic [ROWS-1:0][COLS-1:0] pe_nxt;
    logic                      mode_fwd;
    logic                      mode_bwd;

    assign mode_fwd = (q.st == ST_FWD);
    assign mode_bwd = (q.st == ST_BWD);
    assign col_pos  = COLW'(COLS - 1) - COLW'(q.cnt);

    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            colbits[i] = q.rows[i][col_pos];
        end
    end

    gf2sys_pivot #(
        .ROWS (ROWS),
        .IDXW (IDXW)
    ) u_pivot (
        .colbits  (colbits),
        .from_idx (q.cnt),
        .found    (pvt_found),
        .pvt_idx  (pvt_idx)
    );

    assign pvt_row = mode_fwd ? q.rows[pvt_idx] : q.rows[q.cnt];

    for (genvar g = 0; g < ROWS; g++) begin : g_pe
        gf2sys_pe #(
            .COLS   (COLS),
            .IDXW   (IDXW),
            .COLW   (COLW),
            .MY_IDX (g)
        ) u_pe (
            .mode_fwd (mode_fwd),
            .mode_bwd (mode_bwd),
            .cur_idx  (q.cnt),
            .pvt_idx  (pvt_idx),
            .col_pos  (col_pos),
            .own_row  (q.rows[g]),
            .cur_row  (q.rows[q.cnt]),
            .pvt_row  (pvt_row),
            .nxt_row  (pe_nxt[g])
        );
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.fail = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st  = ST_LOAD;
                    d.cnt = '0;
                end
            end
            ST_LOAD: begin
                if (in_valid) begin
                    d.rows[q.cnt] = in_row;
                    if (q.cnt == LAST_IDX) begin
                        d.st  = ST_FWD;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_FWD: begin
                if (!pvt_found) begin
                    d.st   = ST_IDLE;
                    d.cnt  = '0;
                    d.fail = 1'b1;
                end else begin
                    d.rows = pe_nxt;
                    if (q.cnt == LAST_IDX) begin
                        d.st = ST_BWD;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_BWD: begin
                d.rows = pe_nxt;
                if (q.cnt == IDXW'(1)) begin
                    d.st   = ST_OUT;
                    d.cnt  = '0;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_OUT: begin
                if (out_ready) begin
                    if (q.cnt == LAST_IDX) begin
                        d.st  = ST_IDLE;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready  = (q.st == ST_LOAD);
    assign out_valid = (q.st == ST_OUT);
    assign out_row   = q.rows[q.cnt];
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign fail      = q.fail;

    assert_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (($countones(out_row[COLS-1 -: ROWS]) == 1) &&
                       out_row[COLS-1-int'(q.cnt)]));

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)));

    assert_done_first_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && !fail && (q.cnt == '0)));

    assert_fail_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!busy && !out_valid && !done));

    assert_load_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && start && !in_valid) |=> (in_ready && $stable(q.cnt)));

    assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (in_ready && $past(start)));

endmodule

// File: tb/gf2_sysform_tb.sv
module gf2_sysform_tb;

    localparam int ROWS = 8;
    localparam int COLS = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            in_valid = 1'b0;
    logic [COLS-1:0] in_row = '0;
    logic            out_ready = 1'b0;
    logic            in_ready, busy, done, fail, out_valid;
    logic [COLS-1:0] out_row;

    int vectors = 0;
    int fails   = 0;

    logic [COLS-1:0] mat  [ROWS];
    logic [COLS-1:0] expr [ROWS];
    logic [COLS-1:0] got  [ROWS];

    always #10 clk = ~clk;

    gf2_sysform #(.ROWS(ROWS), .COLS(COLS)) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start),
        .in_valid (in_valid), .in_ready (in_ready), .in_row (in_row),
        .busy (busy), .done (done), .fail (fail),
        .out_valid (out_valid), .out_ready (out_ready), .out_row (out_row)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // software Gauss-Jordan reduction; returns 1 when the left part is singular
    function automatic bit model();
        logic [COLS-1:0] w [ROWS];
        logic [COLS-1:0] t;
        int p;
        for (int r = 0; r < ROWS; r++) w[r] = mat[r];
        for (int c = 0; c < ROWS; c++) begin
            p = -1;
            for (int r = ROWS - 1; r >= c; r--) if (w[r][COLS-1-c]) p = r;
            if (p < 0) return 1'b1;
            t = w[c]; w[c] = w[p]; w[p] = t;
            for (int r = 0; r < ROWS; r++)
                if (r != c && w[r][COLS-1-c]) w[r] = w[r] ^ w[c];
        end
        for (int r = 0; r < ROWS; r++) expr[r] = w[r];
        return 1'b0;
    endfunction

    task automatic build(input int kind);
        for (int r = 0; r < ROWS; r++) mat[r] = COLS'($urandom);
        case (kind)
            0: for (int r = 0; r < ROWS; r++)
                   mat[r][COLS-1 -: ROWS] = ROWS'(1) << (ROWS - 1 - r);
            2: begin mat[0][COLS-1] = 1'b0; mat[3][COLS-1] = 1'b1; end
            3: mat[3] = mat[1] ^ mat[2];
            4: for (int r = 0; r < ROWS; r++) mat[r][COLS-1-5] = 1'b0;
            5: for (int r = 0; r < ROWS; r++)
                   mat[r][COLS-1 -: ROWS] = ROWS'(1) << r;
            default: ;
        endcase
    endtask

    task automatic run(input int gap, input bit stall, input bit poke);
        int n;
        bit fl;
        logic [COLS-1:0] acc;
        logic [ROWS-1:0] one;
        fl = model();
        chk(!busy && !in_ready, "R9 idle before start", busy, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && in_ready, "R9 busy and loading after start", {busy, in_ready}, 3);
        for (int r = 0; r < ROWS; r++) begin
            if (gap > 0 && (r % 2) == 1) begin
                for (int g = 0; g < gap; g++) begin
                    if (poke && g == 0) start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    chk(in_ready, "R4 ready held over gap", in_ready, 1);
                end
            end
            in_valid = 1'b1;
            in_row   = mat[r];
            chk(in_ready, "R4 ready for row", in_ready, 1);
            @(negedge clk);
            in_valid = 1'b0;
        end
        chk(!in_ready, "R4 ready drops after last row", in_ready, 0);
        n = 0;
        while (!(done || fail) && n < 4 * ROWS) begin
            if (poke && n == 2) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        if (fl) begin
            chk(fail && !done, "R6 fail pulse on singular", {fail, done}, 2);
            chk(!out_valid && !busy, "R6 no output, idle", {out_valid, busy}, 0);
            @(negedge clk);
            chk(!fail && !busy && !out_valid, "R6 one-cycle fail then idle", fail, 0);
            return;
        end
        chk(done && n == 2 * ROWS - 1, "R5 done timing", n, 2 * ROWS - 1);
        for (int r = 0; r < ROWS; r++) begin
            if (stall) begin
                out_ready = 1'b0;
                @(negedge clk);
                chk(out_valid && out_row == expr[r], "R7 row held under stall", out_row, expr[r]);
                chk(!done, "R5 done single cycle", done, 0);
            end
            if (r == 1) chk(!done, "R5 done low on second row", done, 0);
            chk(out_valid && out_row == expr[r], "R3 reduced row", out_row, expr[r]);
            one = ROWS'(1) << (ROWS - 1 - r);
            chk(out_row[COLS-1 -: ROWS] == one, "R1 identity block", out_row[COLS-1 -: ROWS], one);
            got[r] = out_row;
            out_ready = 1'b1;
            if (poke && r == 1) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            out_ready = 1'b0;
        end
        chk(!busy && !in_ready && !out_valid, "R8 start ignored, idle after last row R7",
            {busy, in_ready, out_valid}, 0);
        for (int r = 0; r < ROWS; r++) begin
            acc = '0;
            for (int i = 0; i < ROWS; i++) if (mat[r][COLS-1-i]) acc = acc ^ got[i];
            chk(acc == mat[r], "R2 row space preserved", acc, mat[r]);
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !in_ready && !out_valid && !done && !fail, "R10 reset state",
            {busy, in_ready, out_valid, done, fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !in_ready && !out_valid && !done && !fail, "R10 after reset release",
            {busy, in_ready, out_valid, done, fail}, 0);
        build(0); run(0, 1'b0, 1'b0);
        build(2); run(2, 1'b1, 1'b0);
        build(5); run(1, 1'b1, 1'b1);
        build(3); run(0, 1'b0, 1'b1);
        build(4); run(1, 1'b0, 1'b0);
        build(0); run(0, 1'b1, 1'b1);
        for (int k = 0; k < 12; k++) begin
            build(1);
            run(k % 3, k[0], k[1]);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule